// File: doc/BRIEF.md
# Processor Status Word Register Unit

This block keeps the 16-bit status word of a processor core and applies every rule that decides how that word changes from one cycle to the next. Six arithmetic flags (overflow, sign, zero, half carry, parity, carry) follow the results of flag-affecting operations. Five control fields (a 4-bit register-bank select, direction, interrupt enable, single-step break and I/O trap) change only when the core writes them or when an interrupt is taken.

The arithmetic result reaches the unit over a valid/ready stream. `alu_ready` drops in any cycle that carries a stack restore or a low-byte load, because those writes own the status flags in that cycle. While `alu_ready` is low the producer must keep `alu_valid` and its data steady until the item is accepted. An item that is not accepted leaves every flag as it was.

All other inputs are single-cycle strobes with no handshake:

- carry commands,
- control-field writes,
- interrupt entry,
- full-word restore from the stack,
- low-byte load from an accumulator byte.

The full word, its low byte and each flag are available as outputs at all times.

Top module: `psw_unit`

## Requirements
- R1: While `rst_n` is low, and from then until the first update, every bit of `psw_word` is 0. The reset takes effect without waiting for a clock edge.
- R2: Bits 5 and 3 of `psw_word` read 0 in every cycle, even after a restore or byte load whose data has those bits set.
- R3: An accepted ALU item (`alu_valid` and `alu_ready` both high) updates these flags at the next edge, with the word laid out as V=11, S=7, Z=6, AC=4, P=2, CY=0:
  - S takes bit 15 of the result when `alu_wide`=1 and bit 7 when `alu_wide`=0.
  - Z is 1 when the selected width of the result (16 or 8 bits) is all zero.
  - P is 1 when bits 7:0 of the result hold an even number of ones.
  - V, AC and CY take `alu_ovf`, `alu_aux` and `alu_carry`.
- R4: `alu_ready` is 0 in any cycle where `stk_restore` or `byte_load` is high and 1 otherwise. An item that is not accepted changes no flag.
- R5: `cy_cmd` acts on CY (bit 0) and wins over the ALU carry in the same cycle:
  - 2'b01 sets CY.
  - 2'b10 clears CY.
  - 2'b11 inverts the CY value held before the edge.
  - 2'b00 does nothing.
- R6: Each bit of `ctrl_we` writes one control field from its data pin at the next edge:
  - bit 0 writes DIR (bit 10),
  - bit 1 writes IE (bit 9),
  - bit 2 writes BRK (bit 8),
  - bit 3 writes IBRK (bit 1),
  - bit 4 writes RB (bits 15:12).
- R7: `int_entry` makes IE and BRK 0 at the next edge, even if the same cycle writes either of them with 1.
- R8: `stk_restore` loads bits 11:0 of `stk_word` into the word. Bits 15:12 keep their previous value, even when a bank write happens in the same cycle. A restore overrides same-cycle control writes and carry commands.
- R9: `byte_load` loads `byte_in` into bits 7:0 and leaves bits 15:8 alone, apart from same-cycle control writes to high fields. It overrides a same-cycle IBRK write and carry command. If `stk_restore` is also high, the restore wins and the byte is dropped.
- R10: `psw_low` always equals bits 7:0 of `psw_word`, and each `f_*` output equals its bit of the word at the positions given in R3 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_valid | input | 1 | ALU result item is offered |
| alu_ready | output | 1 | ALU item is accepted this cycle |
| alu_result | input | 16 | ALU result value |
| alu_wide | input | 1 | 1: 16-bit operation, 0: 8-bit operation |
| alu_carry | input | 1 | Carry/borrow out of the operation |
| alu_aux | input | 1 | Carry/borrow out of bit 3 |
| alu_ovf | input | 1 | Signed overflow of the operation |
| cy_cmd | input | 2 | Carry command: 01 set, 10 clear, 11 invert |
| ctrl_we | input | 5 | Control-field write enables |
| ctrl_rb | input | 4 | Register-bank select data |
| ctrl_dir | input | 1 | Direction data |
| ctrl_ie | input | 1 | Interrupt-enable data |
| ctrl_brk | input | 1 | Single-step break data |
| ctrl_ibrk | input | 1 | I/O trap data |
| int_entry | input | 1 | Interrupt servicing starts |
| stk_restore | input | 1 | Restore the word from the stack |
| stk_word | input | 16 | Word popped from the stack |
| byte_load | input | 1 | Load the low byte from the accumulator |
| byte_in | input | 8 | Accumulator byte |
| psw_word | output | 16 | Full status word for pushing |
| psw_low | output | 8 | Low byte for a byte move |
| f_cy | output | 1 | Carry flag |
| f_p | output | 1 | Parity flag |
| f_ac | output | 1 | Half-carry flag |
| f_z | output | 1 | Zero flag |
| f_s | output | 1 | Sign flag |
| f_v | output | 1 | Overflow flag |
| f_ibrk | output | 1 | I/O trap flag |
| f_brk | output | 1 | Single-step break flag |
| f_ie | output | 1 | Interrupt enable flag |
| f_dir | output | 1 | Direction flag |
| f_rb | output | 4 | Register-bank select |

## Verification
The bench restores an all-ones word while a bank write is pending. A design that lets the restore or the write reach bits 15:12 shows a changed bank there, and a design that stores the data as given shows ones at bits 5 and 3.

It checks 8-bit results that are zero in the low byte but not in the high byte, and results whose sign sits in bit 7. A design that always computes S and Z over 16 bits gets both flags wrong there.

It inverts the carry in the same cycle as an accepted ALU carry. It also sends a byte load together with an IBRK write and a carry command. A wrong priority leaves the ALU carry or the written IBRK in the word.

It offers an ALU item during a byte load and expects `alu_ready` low with no effect on the arithmetic flags. A design that accepts the item loses the byte-load values.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 16;
  localparam int BYTE_W = 8;
  localparam int RB_W   = 4;

  // Field order matches bit positions 15 down to 0.
  typedef struct packed {
    logic [RB_W-1:0] rb;
    logic            v;
    logic            dir;
    logic            ie;
    logic            brk;
    logic            s;
    logic            z;
    logic            rsv5;
    logic            ac;
    logic            rsv3;
    logic            p;
    logic            ibrk;
    logic            cy;
  } psw_t;

  typedef enum logic [1:0] {
    CY_KEEP = 2'b00,
    CY_SET  = 2'b01,
    CY_CLR  = 2'b10,
    CY_INV  = 2'b11
  } cy_cmd_e;

  localparam int CW_DIR  = 0;
  localparam int CW_IE   = 1;
  localparam int CW_BRK  = 2;
  localparam int CW_IBRK = 3;
  localparam int CW_RB   = 4;
  localparam int CW_N    = 5;
endpackage

// File: rtl/psw_status_calc.sv
module psw_status_calc #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] result,
  input  logic              wide,
  output logic              sign,
  output logic              zero,
  output logic              parity
);
  localparam int HI_W = DATA_W - BYTE_W;

  logic [BYTE_W:0] par_chain;
  logic            lo_zero;
  logic            hi_zero;

  // Parity of the low byte as an explicit xor chain.
  assign par_chain[0] = 1'b0;
  for (genvar i = 0; i < BYTE_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ result[i];
  end

  assign lo_zero = (result[BYTE_W-1:0] == '0);
  assign hi_zero = (result[DATA_W-1:BYTE_W] == {HI_W{1'b0}});

  always_comb begin
    if (wide) begin
      sign = result[DATA_W-1];
      zero = lo_zero & hi_zero;
    end else begin
      sign = result[BYTE_W-1];
      zero = lo_zero;
    end
    parity = ~par_chain[BYTE_W];
  end
endmodule

// File: rtl/psw_carry_unit.sv
module psw_carry_unit
  import psw_pkg::*;
(
  input  logic       cur_cy,
  input  logic       alu_take,
  input  logic       alu_cy,
  input  logic [1:0] cmd,
  output logic       cy_upd,
  output logic       cy_val
);
  cy_cmd_e cmd_e;
  assign cmd_e = cy_cmd_e'(cmd);

  // A carry command takes precedence over the ALU carry.
  always_comb begin
    cy_upd = 1'b1;
    unique case (cmd_e)
      CY_SET:  cy_val = 1'b1;
      CY_CLR:  cy_val = 1'b0;
      CY_INV:  cy_val = ~cur_cy;
      default: begin
        cy_val = alu_cy;
        cy_upd = alu_take;
      end
    endcase
  end
endmodule

// File: rtl/psw_state_reg.sv
module psw_state_reg
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_take,
  input  logic              alu_v,
  input  logic              alu_s,
  input  logic              alu_z,
  input  logic              alu_ac,
  input  logic              alu_p,
  input  logic              cy_upd,
  input  logic              cy_val,
  input  logic [CW_N-1:0]   ctrl_we,
  input  logic [RB_W-1:0]   ctrl_rb,
  input  logic              ctrl_dir,
  input  logic              ctrl_ie,
  input  logic              ctrl_brk,
  input  logic              ctrl_ibrk,
  input  logic              int_entry,
  input  logic              stk_restore,
  input  logic [PSW_W-1:0]  stk_word,
  input  logic              byte_load,
  input  logic [BYTE_W-1:0] byte_in,
  output psw_t              q
);
  psw_t nxt;
  psw_t stk_v;
  psw_t byt_v;

  assign stk_v = psw_t'(stk_word);
  assign byt_v = psw_t'({{(PSW_W-BYTE_W){1'b0}}, byte_in});

  // Lowest priority first; later assignments win.
  always_comb begin
    nxt = q;
    if (alu_take) begin
      nxt.v  = alu_v;
      nxt.s  = alu_s;
      nxt.z  = alu_z;
      nxt.ac = alu_ac;
      nxt.p  = alu_p;
    end
    if (cy_upd) nxt.cy = cy_val;
    if (ctrl_we[CW_DIR])  nxt.dir  = ctrl_dir;
    if (ctrl_we[CW_IE])   nxt.ie   = ctrl_ie;
    if (ctrl_we[CW_BRK])  nxt.brk  = ctrl_brk;
    if (ctrl_we[CW_IBRK]) nxt.ibrk = ctrl_ibrk;
    if (ctrl_we[CW_RB])   nxt.rb   = ctrl_rb;
    if (stk_restore) begin
      nxt    = stk_v;
      nxt.rb = q.rb;
    end else if (byte_load) begin
      nxt.s    = byt_v.s;
      nxt.z    = byt_v.z;
      nxt.ac   = byt_v.ac;
      nxt.p    = byt_v.p;
      nxt.ibrk = byt_v.ibrk;
      nxt.cy   = byt_v.cy;
    end
    if (int_entry) begin
      nxt.ie  = 1'b0;
      nxt.brk = 1'b0;
    end
    nxt.rsv5 = 1'b0;
    nxt.rsv3 = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = PSW_W,
  parameter int LOW_W  = BYTE_W,
  parameter int BANK_W = RB_W,
  parameter int NCTRL  = CW_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_valid,
  output logic              alu_ready,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_wide,
  input  logic              alu_carry,
  input  logic              alu_aux,
  input  logic              alu_ovf,
  input  logic [1:0]        cy_cmd,
  input  logic [NCTRL-1:0]  ctrl_we,
  input  logic [BANK_W-1:0] ctrl_rb,
  input  logic              ctrl_dir,
  input  logic              ctrl_ie,
  input  logic              ctrl_brk,
  input  logic              ctrl_ibrk,
  input  logic              int_entry,
  input  logic              stk_restore,
  input  logic [DATA_W-1:0] stk_word,
  input  logic              byte_load,
  input  logic [LOW_W-1:0]  byte_in,
  output logic [DATA_W-1:0] psw_word,
  output logic [LOW_W-1:0]  psw_low,
  output logic              f_cy,
  output logic              f_p,
  output logic              f_ac,
  output logic              f_z,
  output logic              f_s,
  output logic              f_v,
  output logic              f_ibrk,
  output logic              f_brk,
  output logic              f_ie,
  output logic              f_dir,
  output logic [BANK_W-1:0] f_rb
);
  psw_t st;
  logic alu_take;
  logic calc_s, calc_z, calc_p;
  logic cy_upd, cy_val;

  // Restore and byte load own the status flags, so the stream waits.
  assign alu_ready = ~(stk_restore | byte_load);
  assign alu_take  = alu_valid & alu_ready;

  psw_status_calc #(.DATA_W(DATA_W), .BYTE_W(LOW_W)) u_calc (
    .result (alu_result),
    .wide   (alu_wide),
    .sign   (calc_s),
    .zero   (calc_z),
    .parity (calc_p)
  );

  psw_carry_unit u_carry (
    .cur_cy   (st.cy),
    .alu_take (alu_take),
    .alu_cy   (alu_carry),
    .cmd      (cy_cmd),
    .cy_upd   (cy_upd),
    .cy_val   (cy_val)
  );

  psw_state_reg u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .alu_take    (alu_take),
    .alu_v       (alu_ovf),
    .alu_s       (calc_s),
    .alu_z       (calc_z),
    .alu_ac      (alu_aux),
    .alu_p       (calc_p),
    .cy_upd      (cy_upd),
    .cy_val      (cy_val),
    .ctrl_we     (ctrl_we),
    .ctrl_rb     (ctrl_rb),
    .ctrl_dir    (ctrl_dir),
    .ctrl_ie     (ctrl_ie),
    .ctrl_brk    (ctrl_brk),
    .ctrl_ibrk   (ctrl_ibrk),
    .int_entry   (int_entry),
    .stk_restore (stk_restore),
    .stk_word    (stk_word),
    .byte_load   (byte_load),
    .byte_in     (byte_in),
    .q           (st)
  );

  assign psw_word = st;
  assign psw_low  = psw_word[LOW_W-1:0];
  assign f_cy   = st.cy;
  assign f_p    = st.p;
  assign f_ac   = st.ac;
  assign f_z    = st.z;
  assign f_s    = st.s;
  assign f_v    = st.v;
  assign f_ibrk = st.ibrk;
  assign f_brk  = st.brk;
  assign f_ie   = st.ie;
  assign f_dir  = st.dir;
  assign f_rb   = st.rb;
endmodule

// File: rtl/psw_chk.sv
module psw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        alu_valid,
  input logic        alu_ready,
  input logic [15:0] alu_result,
  input logic        alu_wide,
  input logic [1:0]  cy_cmd,
  input logic [4:0]  ctrl_we,
  input logic        ctrl_ie,
  input logic        int_entry,
  input logic        stk_restore,
  input logic        byte_load,
  input logic [7:0]  byte_in,
  input logic [15:0] psw_word,
  input logic [7:0]  psw_low
);
  AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_word[5] == 1'b0) && (psw_word[3] == 1'b0)); // R2
  AST_ALU_ZERO_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_ready && alu_wide && alu_result == 16'h0) |=> psw_word[6]); // R3
  AST_ALU_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_ready && alu_result[7:0] == 8'h00) |=> psw_word[2]); // R3
  AST_STALL_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_restore || byte_load) |-> !alu_ready); // R4
  AST_CY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cy_cmd == 2'b01 && !stk_restore && !byte_load) |=> psw_word[0]); // R5
  AST_CY_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (cy_cmd == 2'b11 && !stk_restore && !byte_load) |=> psw_word[0] != $past(psw_word[0])); // R5
  AST_IE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we[1] && !int_entry && !stk_restore) |=> psw_word[9] == $past(ctrl_ie)); // R6
  AST_INT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    int_entry |=> (!psw_word[9] && !psw_word[8])); // R7
  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stk_restore |=> psw_word[15:12] == $past(psw_word[15:12])); // R8
  AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_load && !stk_restore) |=> psw_low == ($past(byte_in) & 8'hD7)); // R9
endmodule

bind psw_unit psw_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alu_valid   (alu_valid),
  .alu_ready   (alu_ready),
  .alu_result  (alu_result),
  .alu_wide    (alu_wide),
  .cy_cmd      (cy_cmd),
  .ctrl_we     (ctrl_we),
  .ctrl_ie     (ctrl_ie),
  .int_entry   (int_entry),
  .stk_restore (stk_restore),
  .byte_load   (byte_load),
  .byte_in     (byte_in),
  .psw_word    (psw_word),
  .psw_low     (psw_low)
);

// File: tb/tb_psw_unit.sv
`timescale 1ns/100ps
module tb_psw_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        alu_valid, alu_wide, alu_carry, alu_aux, alu_ovf;
  logic        alu_ready;
  logic [15:0] alu_result;
  logic [1:0]  cy_cmd;
  logic [4:0]  ctrl_we;
  logic [3:0]  ctrl_rb;
  logic        ctrl_dir, ctrl_ie, ctrl_brk, ctrl_ibrk;
  logic        int_entry, stk_restore, byte_load;
  logic [15:0] stk_word;
  logic [7:0]  byte_in;
  logic [15:0] psw_word;
  logic [7:0]  psw_low;
  logic        f_cy, f_p, f_ac, f_z, f_s, f_v, f_ibrk, f_brk, f_ie, f_dir;
  logic [3:0]  f_rb;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t       sb[$];
  logic [15:0] exp_q = 16'h0;

  always #2 clk = ~clk;

  psw_unit dut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    alu_valid = 0; alu_wide = 0; alu_carry = 0; alu_aux = 0; alu_ovf = 0;
    alu_result = 16'h0; cy_cmd = 2'b00; ctrl_we = 5'h0; ctrl_rb = 4'h0;
    ctrl_dir = 0; ctrl_ie = 0; ctrl_brk = 0; ctrl_ibrk = 0;
    int_entry = 0; stk_restore = 0; stk_word = 16'h0; byte_load = 0; byte_in = 8'h0;
  endtask

  // Reference model written from the requirements.
  function automatic logic [15:0] model(input logic [15:0] c);
    logic [15:0] n = c;
    if (alu_valid && !(stk_restore || byte_load)) begin
      n[11] = alu_ovf;
      n[7]  = alu_wide ? alu_result[15] : alu_result[7];
      n[6]  = alu_wide ? (alu_result == 16'h0) : (alu_result[7:0] == 8'h0);
      n[4]  = alu_aux;
      n[2]  = ~^alu_result[7:0];
      n[0]  = alu_carry;
    end
    case (cy_cmd)
      2'b01: n[0] = 1'b1;
      2'b10: n[0] = 1'b0;
      2'b11: n[0] = ~c[0];
      default: ;
    endcase
    if (ctrl_we[0]) n[10] = ctrl_dir;
    if (ctrl_we[1]) n[9] = ctrl_ie;
    if (ctrl_we[2]) n[8] = ctrl_brk;
    if (ctrl_we[3]) n[1] = ctrl_ibrk;
    if (ctrl_we[4]) n[15:12] = ctrl_rb;
    if (stk_restore) n = {c[15:12], stk_word[11:0]};
    else if (byte_load) n[7:0] = byte_in;
    if (int_entry) begin n[9] = 1'b0; n[8] = 1'b0; end
    n[5] = 1'b0;
    n[3] = 1'b0;
    return n;
  endfunction

  // Driver: inputs already set at a falling edge; push the expectation.
  task automatic go(input string tag);
    item_t it;
    it.exp = model(exp_q);
    it.tag = tag;
    sb.push_back(it);
    exp_q = it.exp;
    @(negedge clk);
    idle();
  endtask

  // Monitor: compare just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, psw_word, it.exp);
      chk("R10 low byte", {8'h0, psw_low}, {8'h0, it.exp[7:0]});
      chk("R10 flag pins",
          {f_rb, f_v, f_dir, f_ie, f_brk, f_s, f_z, f_ac, f_p, f_ibrk, f_cy, 2'b00},
          {it.exp[15:6], it.exp[4], it.exp[2:0], 2'b00});
    end
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset value", psw_word, 16'h0);
    rst_n = 1;
    @(negedge clk);
    go("R1 idle after reset");

    ctrl_we = 5'h1F; ctrl_rb = 4'b0101; ctrl_dir = 1; ctrl_ie = 1; ctrl_brk = 1; ctrl_ibrk = 1;
    go("R6 write all control fields");
    ctrl_we = 5'h01; ctrl_dir = 0;
    go("R6 clear direction only");

    alu_valid = 1; alu_wide = 1; alu_result = 16'h0000; alu_carry = 1; alu_aux = 1;
    go("R3 wide zero result");
    alu_valid = 1; alu_wide = 0; alu_result = 16'h0080; alu_ovf = 1;
    go("R3 byte sign from bit 7, odd parity");
    alu_valid = 1; alu_wide = 0; alu_result = 16'h1200;
    go("R3 byte zero ignores high byte");
    alu_valid = 1; alu_wide = 1; alu_result = 16'h1200;
    go("R3 wide nonzero");
    alu_valid = 1; alu_wide = 1; alu_result = 16'h8003; alu_carry = 1;
    go("R3 wide sign from bit 15");

    cy_cmd = 2'b10;
    go("R5 clear carry");
    cy_cmd = 2'b01;
    go("R5 set carry");
    cy_cmd = 2'b11;
    go("R5 invert carry");
    alu_valid = 1; alu_wide = 1; alu_result = 16'h0001; alu_carry = 0; cy_cmd = 2'b11;
    go("R5 invert wins over ALU carry");

    ctrl_we = 5'h06; ctrl_ie = 1; ctrl_brk = 1;
    go("R6 set IE and BRK");
    int_entry = 1; ctrl_we = 5'h06; ctrl_ie = 1; ctrl_brk = 1;
    go("R7 interrupt entry beats writes");

    stk_restore = 1; stk_word = 16'hFFFF; ctrl_we = 5'h10; ctrl_rb = 4'b1010; cy_cmd = 2'b10;
    go("R8 restore keeps bank, R2 reserved zero");
    stk_restore = 1; stk_word = 16'h0000;
    go("R8 restore zeros");

    ctrl_we = 5'h09; ctrl_dir = 1; ctrl_ibrk = 0;
    byte_load = 1; byte_in = 8'hFF; cy_cmd = 2'b10;
    go("R9 byte load beats IBRK write, R2");
    stk_restore = 1; stk_word = 16'h0A55; byte_load = 1; byte_in = 8'h00;
    go("R9 restore wins over byte load");

    byte_load = 1; byte_in = 8'h00; alu_valid = 1; alu_wide = 1;
    alu_result = 16'h8001; alu_ovf = 1; alu_aux = 1; alu_carry = 1;
    #1 chk("R4 ready low during byte load", {15'h0, alu_ready}, 16'h0);
    go("R4 stalled item has no effect");
    alu_valid = 1; alu_wide = 1; alu_result = 16'h8001; alu_ovf = 1; alu_aux = 1; alu_carry = 1;
    #1 chk("R4 ready high when free", {15'h0, alu_ready}, 16'h1);
    go("R4 held item accepted");

    rst_n = 0;
    #1 chk("R1 asynchronous reset", psw_word, 16'h0);
    exp_q = 16'h0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    go("R1 state after second reset");
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule